// File: doc/BRIEF.md
# Eight-Channel DAC Update Sequencer

This block holds the next value for each of eight 16-bit converter channels. It decides when those values reach the converter-facing outputs. Software writes channel values over a simple register port. In direct mode a write reaches its output on the next clock. In the three sequenced modes the writes stay in a holding buffer. All channels then move to the outputs together on one trigger. The trigger comes from a software command, a rising edge on an external pin, or a programmable period counter that runs on the block clock.

Software and the sequencer hand data over with two flags. After each transfer of fresh data the block raises a request flag and an interrupt, and marks its buffer as unconfirmed. Software refills the buffer and writes 1 to the request bit. That confirms the new data and acknowledges the interrupt. If a trigger comes before this confirmation, the outputs repeat their previous values and the flags stay as they are.

The accepted trigger is sent out as a one-cycle pulse, together with an output enable for a shared I/O line. While the enable is set, it takes precedence over that line's direction setting. One combination is refused: external-trigger mode with the trigger output enabled. In that state the block raises a configuration error and ignores external triggers, so the sequencer cannot lock.

Top module: `dac_update_seq`

## Requirements
- R1: After reset all channel outputs are 0, `dac_load`, `irq` and `trig_out` are 0, and the status word (address 9) reads 0x2: request (bit 0) 0, underflow (bit 1) 1, interrupt pending (bit 2) 0, all higher bits 0.
- R2: Channel registers sit at addresses 0 to 7. A read returns the last written low 16 bits, and bits 31:16 read 0.
- R3: In direct mode (control bits 1:0 = 0 at address 8) a channel write changes that channel's output at the next clock edge, and `dac_load` is high for that one cycle.
- R4: In modes 1 to 3 a channel write changes no output. Outputs change only in a cycle where `dac_load` is high.
- R5: In mode 3, writing the control register with bit 4 set issues a software trigger. It acts at the same clock edge as the write, and bit 4 reads back 0.
- R6: In mode 1 a rising edge on `ext_trig` is synchronised by two flops. It acts at the third clock edge after the rise.
- R7: In mode 2 a trigger fires every P+1 clock cycles, where P is the period register at address 10. The counter restarts whenever the block enters mode 2.
- R8: A trigger while the data is confirmed (underflow 0) copies all eight buffered values to the outputs at once. It sets request and underflow, and sets the interrupt when control bit 3 is 1.
- R9: Writing status with bit 0 = 1 confirms the data: request, underflow and interrupt all clear. Writing status with bit 0 = 0 has no effect.
- R10: A trigger while underflow is 1 leaves all outputs unchanged. It pulses `dac_load`, and request, underflow and interrupt keep their values.
- R11: With mode 1 and control bit 2 (trigger output enable) both set, `cfg_err` is 1 and external edges cause no trigger.
- R12: Every accepted trigger gives a one-cycle `trig_out` pulse in the same cycle as `dac_load`. `trig_oe` follows control bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the period counter's time base |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 32 | Read data, combinational from `rd_addr` |
| ext_trig | input | 1 | External trigger pin, asynchronous |
| dac_data | output | 128 | Eight 16-bit channel outputs, channel 0 in the low bits |
| dac_load | output | 1 | One-cycle pulse when the outputs were (re)loaded |
| irq | output | 1 | Interrupt pending |
| trig_out | output | 1 | Accepted trigger, driven to the shared line |
| trig_oe | output | 1 | Drive enable for the shared line |
| cfg_err | output | 1 | Forbidden mode combination is active |

## Verification
The bench fires triggers before software has confirmed data. A design that reloaded anyway would show buffered values that software never confirmed. A design that re-raised the request would show status 0x7 where 0x2 is expected. It writes a status word with bit 0 clear to catch a design that clears flags on any status write. It counts cycles on the external path and on the period counter, which exposes a missing or extra synchroniser flop and an off-by-one period. It pulses the external pin in the forbidden mode, where a design without the block would transfer data. Random sequences of channel writes, confirmations and software triggers are checked against a bench model.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;
  typedef enum logic [1:0] {
    MODE_DIRECT = 2'd0,
    MODE_EXT    = 2'd1,
    MODE_TIMER  = 2'd2,
    MODE_SOFT   = 2'd3
  } seq_mode_e;

  localparam int unsigned REG_AW = 4;
  localparam logic [REG_AW-1:0] ADDR_CTRL = 4'd8;
  localparam logic [REG_AW-1:0] ADDR_STAT = 4'd9;
  localparam logic [REG_AW-1:0] ADDR_PER  = 4'd10;
endpackage

// File: rtl/dac_seq_trig.sv
module dac_seq_trig
  import dac_seq_pkg::*;
#(
  parameter int unsigned TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  seq_mode_e     mode,
  input  logic [TW-1:0] period,
  input  logic          sw_hit,
  input  logic          ext_in,
  input  logic          ext_block,
  output logic          fire
);
  logic [2:0]    sync_q;
  logic [TW-1:0] cnt_q;
  logic          ext_edge, tmr_hit;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[1:0], ext_in};
  end

  assign ext_edge = sync_q[1] & ~sync_q[2];
  assign tmr_hit  = (mode == MODE_TIMER) && (cnt_q == period);

  always_ff @(posedge clk) begin
    if (rst || mode != MODE_TIMER || tmr_hit) cnt_q <= '0;
    else                                      cnt_q <= cnt_q + 1'b1;
  end

  assign fire = (ext_edge && mode == MODE_EXT && !ext_block)
              || tmr_hit
              || (sw_hit && mode == MODE_SOFT);
endmodule

// File: rtl/dac_seq_bank.sv
module dac_seq_bank #(
  parameter int unsigned NCH = 8,
  parameter int unsigned DW  = 16,
  localparam int unsigned CW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_hit,
  input  logic [CW-1:0]     wr_ch,
  input  logic [DW-1:0]     wr_val,
  input  logic              direct,
  input  logic              xfer,
  input  logic              fire,
  input  logic [CW-1:0]     rd_ch,
  output logic [DW-1:0]     rd_val,
  output logic [NCH*DW-1:0] out_flat,
  output logic              load
);
  logic [NCH*DW-1:0] hold_flat;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [DW-1:0] hold_q, out_q;
    logic          sel;
    assign sel = wr_hit && (wr_ch == CW'(g));
    always_ff @(posedge clk) begin
      if (rst) begin
        hold_q <= '0;
        out_q  <= '0;
      end else begin
        if (sel) hold_q <= wr_val;
        if (sel && direct) out_q <= wr_val;
        else if (xfer)     out_q <= hold_q;
      end
    end
    assign hold_flat[g*DW +: DW] = hold_q;
    assign out_flat[g*DW +: DW]  = out_q;
  end

  assign rd_val = hold_flat[rd_ch*DW +: DW];

  always_ff @(posedge clk) begin
    if (rst) load <= 1'b0;
    else     load <= fire || (wr_hit && direct);
  end
endmodule

// File: rtl/dac_seq_stat.sv
module dac_seq_stat (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  input  logic confirm,
  input  logic irq_en,
  output logic xfer,
  output logic req,
  output logic unf,
  output logic irq
);
  logic ready;
  assign ready = !unf || confirm;
  assign xfer  = fire && ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      req <= 1'b0;
      unf <= 1'b1;
      irq <= 1'b0;
    end else if (xfer) begin
      req <= 1'b1;
      unf <= 1'b1;
      irq <= irq_en;
    end else if (confirm) begin
      req <= 1'b0;
      unf <= 1'b0;
      irq <= 1'b0;
    end
  end
endmodule

// File: rtl/dac_update_seq.sv
module dac_update_seq
  import dac_seq_pkg::*;
#(
  parameter int unsigned NCH = 8,
  parameter int unsigned DW  = 16,
  parameter int unsigned TW  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [3:0]        wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [3:0]        rd_addr,
  output logic [31:0]       rd_data,
  input  logic              ext_trig,
  output logic [NCH*DW-1:0] dac_data,
  output logic              dac_load,
  output logic              irq,
  output logic              trig_out,
  output logic              trig_oe,
  output logic              cfg_err
);
  localparam int unsigned CW = $clog2(NCH);

  seq_mode_e     mode_q;
  logic          oe_q, irqen_q, trig_q;
  logic [TW-1:0] per_q;
  logic          ctrl_wr, sw_hit, confirm, ch_wr, fire, xfer, req, unf;
  logic [DW-1:0] rd_val;
  logic          unused_bits;

  assign ctrl_wr = wr_en && wr_addr == ADDR_CTRL;
  assign sw_hit  = ctrl_wr && wr_data[4];
  assign confirm = wr_en && wr_addr == ADDR_STAT && wr_data[0];
  assign ch_wr   = wr_en && wr_addr < 4'(NCH);
  assign cfg_err = mode_q == MODE_EXT && oe_q;
  assign unused_bits = ^wr_data[31:DW];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MODE_DIRECT;
      oe_q    <= 1'b0;
      irqen_q <= 1'b0;
      per_q   <= '0;
      trig_q  <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        mode_q  <= seq_mode_e'(wr_data[1:0]);
        oe_q    <= wr_data[2];
        irqen_q <= wr_data[3];
      end
      if (wr_en && wr_addr == ADDR_PER) per_q <= wr_data[TW-1:0];
      trig_q <= fire;
    end
  end

  dac_seq_trig #(.TW(TW)) trig_i (
    .clk(clk), .rst(rst), .mode(mode_q), .period(per_q), .sw_hit(sw_hit),
    .ext_in(ext_trig), .ext_block(cfg_err), .fire(fire)
  );

  dac_seq_stat stat_i (
    .clk(clk), .rst(rst), .fire(fire), .confirm(confirm), .irq_en(irqen_q),
    .xfer(xfer), .req(req), .unf(unf), .irq(irq)
  );

  dac_seq_bank #(.NCH(NCH), .DW(DW)) bank_i (
    .clk(clk), .rst(rst), .wr_hit(ch_wr), .wr_ch(wr_addr[CW-1:0]),
    .wr_val(wr_data[DW-1:0]), .direct(mode_q == MODE_DIRECT), .xfer(xfer),
    .fire(fire), .rd_ch(rd_addr[CW-1:0]), .rd_val(rd_val),
    .out_flat(dac_data), .load(dac_load)
  );

  always_comb begin
    rd_data = '0;
    if (rd_addr < 4'(NCH))          rd_data[DW-1:0] = rd_val;
    else if (rd_addr == ADDR_CTRL)  rd_data[3:0]    = {irqen_q, oe_q, mode_q};
    else if (rd_addr == ADDR_STAT)  rd_data[2:0]    = {irq, unf, req};
    else if (rd_addr == ADDR_PER)   rd_data[TW-1:0] = per_q;
  end

  assign trig_out = trig_q;
  assign trig_oe  = oe_q;
endmodule

// File: rtl/dac_update_seq_chk.sv
module dac_update_seq_chk #(
  parameter int unsigned NCH = 8,
  parameter int unsigned DW  = 16,
  parameter int unsigned TW  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [3:0]        wr_addr,
  input logic [31:0]       wr_data,
  input logic [3:0]        rd_addr,
  input logic [31:0]       rd_data,
  input logic              ext_trig,
  input logic [NCH*DW-1:0] dac_data,
  input logic              dac_load,
  input logic              irq,
  input logic              trig_out,
  input logic              trig_oe,
  input logic              cfg_err
);
  // R4
  outputs_only_on_load_chk: assert property (@(posedge clk) disable iff (rst)
    (dac_data != $past(dac_data)) |-> dac_load);

  // R8
  irq_rises_on_transfer_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> (dac_load && trig_out));

  // R9
  confirm_clears_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 4'd9 && wr_data[0]) |=> (!irq || trig_out));

  // R11
  locked_no_trigger_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_err && $past(cfg_err)) |-> !trig_out);

  // R12
  trig_with_load_chk: assert property (@(posedge clk) disable iff (rst)
    trig_out |-> dac_load);
endmodule

bind dac_update_seq dac_update_seq_chk #(.NCH(NCH), .DW(DW), .TW(TW)) chk_i (.*);

// File: tb/dac_update_seq_tb_top.sv
module dac_update_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        ext_trig = 1'b0;
  logic [127:0] dac_data;
  logic        dac_load, irq, trig_out, trig_oe, cfg_err;

  int errs = 0;
  int checks = 0;
  logic [15:0] mb [8];
  logic [15:0] mo [8];
  bit mreq, munf, mirq;

  always #10 clk = ~clk;

  dac_update_seq dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ext_trig(ext_trig),
    .dac_data(dac_data), .dac_load(dac_load), .irq(irq), .trig_out(trig_out),
    .trig_oe(trig_oe), .cfg_err(cfg_err)
  );

  function automatic logic [31:0] exp_stat();
    return {29'd0, mirq, munf, mreq};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic m_fire();
    if (!munf) begin
      for (int i = 0; i < 8; i++) mo[i] = mb[i];
      mreq = 1; munf = 1; mirq = 1;
    end
  endtask

  task automatic m_conf();
    mreq = 0; munf = 0; mirq = 0;
  endtask

  task automatic check_all(input string req);
    logic [31:0] v;
    for (int i = 0; i < 8; i++) chk(req, {16'd0, dac_data[i*16 +: 16]}, {16'd0, mo[i]});
    rd(4'd9, v);
    chk(req, v, exp_stat());
    chk(req, {31'd0, irq}, {31'd0, mirq});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog actual=running expected=done");
    report();
  end

  initial begin
    logic [31:0] v;
    int pulses;
    void'($urandom(32'd2024));
    for (int i = 0; i < 8; i++) begin mb[i] = '0; mo[i] = '0; end
    mreq = 0; munf = 1; mirq = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check_all("R1");
    chk("R1", {29'd0, dac_load, trig_out, trig_oe}, 32'd0);

    // R2 / R3 direct mode write
    wr(4'd5, 32'hABCD_1234);
    mb[5] = 16'h1234; mo[5] = 16'h1234;
    chk("R3", {31'd0, dac_load}, 32'd1);
    chk("R3", {16'd0, dac_data[5*16 +: 16]}, 32'h1234);
    rd(4'd5, v);
    chk("R2", v, 32'h0000_1234);
    @(negedge clk);
    chk("R3", {31'd0, dac_load}, 32'd0);

    // R4 buffered writes in software-trigger mode
    wr(4'd8, 32'h0B);
    for (int i = 0; i < 8; i++) begin
      mb[i] = 16'(32'h1111 * (i + 1));
      wr(4'(i), {16'hFFFF, mb[i]});
    end
    check_all("R4");
    chk("R4", {31'd0, dac_load}, 32'd0);

    // R10 trigger before confirmation repeats outputs
    wr(4'd8, 32'h1B);
    chk("R10", {31'd0, dac_load}, 32'd1);
    check_all("R10");

    // R9 confirm
    wr(4'd9, 32'h1);
    m_conf();
    check_all("R9");

    // R5 / R8 software trigger transfers
    wr(4'd8, 32'h1B);
    m_fire();
    chk("R5", {31'd0, trig_out}, 32'd1);
    check_all("R8");
    rd(4'd8, v);
    chk("R5", v, 32'h0B);

    // R9 writing 0 to bit 0 has no effect
    wr(4'd9, 32'h6);
    check_all("R9");
    wr(4'd9, 32'h1);
    m_conf();
    check_all("R9");

    // random mix in software-trigger mode
    for (int k = 0; k < 80; k++) begin
      int op = int'($urandom_range(0, 2));
      if (op == 0) begin
        int c = int'($urandom_range(0, 7));
        mb[c] = 16'($urandom);
        wr(4'(c), {16'($urandom), mb[c]});
      end else if (op == 1) begin
        wr(4'd9, 32'h1);
        m_conf();
      end else begin
        wr(4'd8, 32'h1B);
        m_fire();
        chk("R12", {30'd0, trig_out, dac_load}, 32'd3);
      end
      check_all("R8");
    end

    // R6 external trigger latency
    wr(4'd9, 32'h1);
    m_conf();
    mb[2] = 16'h5A5A;
    wr(4'd2, 32'h5A5A);
    wr(4'd8, 32'h09);
    chk("R11", {31'd0, cfg_err}, 32'd0);
    ext_trig = 1'b1;
    @(negedge clk);
    chk("R6", {31'd0, dac_load}, 32'd0);
    @(negedge clk);
    chk("R6", {31'd0, dac_load}, 32'd0);
    @(negedge clk);
    chk("R6", {30'd0, trig_out, dac_load}, 32'd3);
    m_fire();
    check_all("R6");
    ext_trig = 1'b0;
    repeat (2) @(negedge clk);

    // R11 locked combination
    wr(4'd8, 32'h0D);
    wr(4'd9, 32'h1);
    m_conf();
    mb[0] = 16'hC0DE;
    wr(4'd0, 32'hC0DE);
    chk("R11", {31'd0, cfg_err}, 32'd1);
    chk("R12", {31'd0, trig_oe}, 32'd1);
    ext_trig = 1'b1;
    pulses = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (trig_out || dac_load) pulses++;
    end
    ext_trig = 1'b0;
    chk("R11", 32'(pulses), 32'd0);
    check_all("R11");

    // R7 period counter
    wr(4'd10, 32'd4);
    wr(4'd8, 32'h0A);
    chk("R12", {31'd0, trig_oe}, 32'd0);
    pulses = 0;
    for (int i = 1; i <= 20; i++) begin
      @(negedge clk);
      if (trig_out) begin
        pulses++;
        if (i % 5 != 0) chk("R7", 32'(i), 32'(((i / 5) + 1) * 5));
      end
    end
    chk("R7", 32'(pulses), 32'd4);
    m_fire();
    wr(4'd8, 32'h08);
    check_all("R7");

    report();
  end
endmodule